// File: doc/BRIEF.md
# Interior-Pixel Write Address Sequencer

This block produces the write addresses for the filtered pixels of a square image of `IMG_DIM` by `IMG_DIM` pixels stored in raster order in an output memory. A neighbourhood filter cannot produce a result for the outermost ring of pixels, so the block visits only the interior. It skips the top and bottom rows, and the leftmost and rightmost pixel of every row in between. For the default 16 by 16 image the addresses run 17 to 30, then 33 to 46, then 49 and onward, ending at 238.

Two loadable counters sit behind it. An address counter steps by one on every accepted write. A small column counter counts the writes within an interior row. When that counter reaches its terminal count, the address counter is reloaded from a row-base register, which then advances by one image row. No row or column arithmetic is done on the address itself. The filter pulses `en` each time it has a result ready. The block turns that pulse into a write strobe with the matching address, and it raises `done` once the last interior pixel has been written.

Top module: `interior_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to idle. After that edge `wr_en` and `done` are low and `wr_addr` is 0.
- R2: A cycle with `start` high produces no write. After that edge `wr_addr` is `IMG_DIM+1` (17 by default) and `done` is low. This applies in any state, including in the middle of a frame.
- R3: `wr_en` is combinationally equal to `en` while a frame is running and `start` is low. It is low at all other times.
- R4: Within an interior row, each write moves `wr_addr` up by exactly one on the following edge.
- R5: After the `IMG_DIM-2`-th write of a row, `wr_addr` jumps by three to the first interior address of the next row. For example 30 becomes 33, and 46 becomes 49.
- R6: A running cycle with `en` low leaves `wr_addr` and the position within the frame unchanged.
- R7: Over one frame the written addresses are exactly r·IMG_DIM + c, for r and c each from 1 to `IMG_DIM-2`. They come in raster order, and each address is written once.
- R8: The edge that takes the write at address (IMG_DIM-2)·IMG_DIM + IMG_DIM-2 (238 by default) raises `done`. `done` then stays high until the next `start`.
- R9: Before the first `start`, and while `done` is high, `en` has no effect. `wr_en` stays low and `wr_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new frame at the first interior pixel |
| en | input | 1 | A filtered pixel is ready to be written this cycle |
| wr_addr | output | $clog2(IMG_DIM*IMG_DIM) | Output memory address for the current pixel |
| wr_en | output | 1 | Write strobe for the output memory |
| done | output | 1 | All interior pixels of the frame have been written |

## Verification
The bench builds the block with the default `IMG_DIM` of 16. This gives 8-bit addresses, a column counter that runs 0 to 13, and 14 row reloads per frame. The whole 196-address frame is therefore compared against a raster list that the bench computes on its own. This covers every row jump, the final reload to 241 and the move into the done state. Gapped enable patterns, a restart in the middle of a frame, `start` together with `en`, and enables before the first start and after completion are all checked on every cycle.

// File: rtl/rcnt_pkg.sv
// Package: shared types for the interior-pixel address sequencer.
// Assumes nothing beyond a single clock domain.
package rcnt_pkg;

    // Frame progress of the sequencer.
    typedef enum logic [1:0] {
        RC_IDLE = 2'd0,
        RC_RUN  = 2'd1,
        RC_DONE = 2'd2
    } rc_state_e;

endpackage

// File: rtl/rcnt_col_counter.sv
// Column counter: counts accepted writes within one interior row.
// It flags the terminal count combinationally on the write that ends the row
// and wraps to zero on that same edge.
// Assumes LAST fits in COL_W bits.
module rcnt_col_counter #(
    parameter int COL_W = 4,
    parameter int LAST  = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic tc
);

    localparam logic [COL_W-1:0] LAST_V = COL_W'(LAST);

    logic [COL_W-1:0] cnt_q;

    // Terminal count: the accepted write is the last one of the row.
    always_comb begin
        tc = adv && (cnt_q == LAST_V);
    end

    // Count position in the row; restart on clear or on terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            if (cnt_q == LAST_V) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rcnt_addr_counter.sv
// Address counter: a loadable up counter that holds the current write address.
// A load takes priority over an increment.
// Assumes load and adv come from the same controller.
module rcnt_addr_counter #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] addr_q;

    // Load, increment or hold the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (adv) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/rcnt_base_reg.sv
// Row-base register: holds the first interior address of the next row.
// It moves on by one image row each time a row is finished.
// at_end tells the controller that no further interior row exists.
// Assumes END_V is reached from INIT_V in whole steps of STEP_V.
module rcnt_base_reg #(
    parameter int AW     = 8,
    parameter int INIT_V = 33,
    parameter int STEP_V = 16,
    parameter int END_V  = 241
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          bump,
    output logic [AW-1:0] base,
    output logic          at_end
);

    localparam logic [AW-1:0] INIT_L = AW'(INIT_V);
    localparam logic [AW-1:0] STEP_L = AW'(STEP_V);
    localparam logic [AW-1:0] END_L  = AW'(END_V);

    logic [AW-1:0] base_q;

    // Flag that the held base lies past the last interior row.
    always_comb begin
        at_end = (base_q == END_L);
    end

    // Preset on frame start; advance one row per finished row, stop at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= INIT_L;
        end else if (init) begin
            base_q <= INIT_L;
        end else if (bump && !at_end) begin
            base_q <= base_q + STEP_L;
        end
    end

    assign base = base_q;

endmodule

// File: rtl/rcnt_ctrl.sv
// Controller: tracks frame progress (idle, running, done).
// It qualifies the enable into a step and marks the final write of the frame.
// Assumes row_tc is only ever high in a cycle where step is high.
module rcnt_ctrl
    import rcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic en,
    input  logic row_tc,
    input  logic base_end,
    output logic step,
    output logic last,
    output logic done
);

    rc_state_e state_q;

    // An accepted write: running, enabled, not overridden by a start.
    always_comb begin
        step = en && (state_q == RC_RUN) && !start;
        last = row_tc && base_end;
        done = (state_q == RC_DONE);
    end

    // Advance frame progress on start and on the final write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RC_IDLE;
        end else if (start) begin
            state_q <= RC_RUN;
        end else if (last) begin
            state_q <= RC_DONE;
        end
    end

endmodule

// File: rtl/interior_addr_gen.sv
// Top: interior-pixel write address sequencer for an IMG_DIM x IMG_DIM image.
// On start the address counter loads the first interior address. Each
// accepted write advances it by one. The column counter's terminal count
// reloads it from the row-base register, which then advances by IMG_DIM.
// Assumes IMG_DIM >= 4 and a raster-ordered output memory.
module interior_addr_gen #(
    parameter int IMG_DIM = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    input  logic                                  en,
    output logic [$clog2(IMG_DIM*IMG_DIM)-1:0]    wr_addr,
    output logic                                  wr_en,
    output logic                                  done
);

    localparam int AW        = $clog2(IMG_DIM * IMG_DIM);
    localparam int ROW_LEN   = IMG_DIM - 2;
    localparam int COL_W     = (ROW_LEN > 1) ? $clog2(ROW_LEN) : 1;
    localparam int FIRST_A   = IMG_DIM + 1;
    localparam int SECOND_A  = 2 * IMG_DIM + 1;
    localparam int END_BASE  = (IMG_DIM - 1) * IMG_DIM + 1;
    localparam logic [AW-1:0] FIRST_L = AW'(FIRST_A);

    logic          step;
    logic          col_tc;
    logic          base_end;
    logic          last;
    logic [AW-1:0] row_base;
    logic          addr_load;
    logic [AW-1:0] addr_load_val;

    rcnt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .en       (en),
        .row_tc   (col_tc),
        .base_end (base_end),
        .step     (step),
        .last     (last),
        .done     (done)
    );

    rcnt_col_counter #(
        .COL_W (COL_W),
        .LAST  (ROW_LEN - 1)
    ) u_col (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .adv   (step),
        .tc    (col_tc)
    );

    rcnt_base_reg #(
        .AW     (AW),
        .INIT_V (SECOND_A),
        .STEP_V (IMG_DIM),
        .END_V  (END_BASE)
    ) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (start),
        .bump   (col_tc),
        .base   (row_base),
        .at_end (base_end)
    );

    // Choose the reload source: frame start or next-row base.
    always_comb begin
        addr_load     = start || col_tc;
        addr_load_val = start ? FIRST_L : row_base;
    end

    rcnt_addr_counter #(
        .AW (AW)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load),
        .load_val (addr_load_val),
        .adv      (step),
        .addr     (wr_addr)
    );

    // The write strobe is the qualified step.
    assign wr_en = step;

endmodule

// File: rtl/interior_addr_gen_chk.sv
// Checker: temporal properties of the interior-pixel address sequencer.
// Attached to every instance of the top module through bind.
module interior_addr_gen_chk #(
    parameter int IMG_DIM = 16,
    parameter int AW      = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          en,
    input logic [AW-1:0] wr_addr,
    input logic          wr_en,
    input logic          done,
    input logic          col_tc
);

    localparam int FIRST_A = IMG_DIM + 1;
    localparam int LO_A    = IMG_DIM + 1;
    localparam int HI_A    = (IMG_DIM - 2) * IMG_DIM + IMG_DIM - 2;

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (!done && wr_addr == '0)); // R1

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (wr_addr == AW'(FIRST_A) && !done)); // R2

    AST_NO_WRITE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (en && !done && !start)); // R3

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !col_tc) |=> (wr_addr == $past(wr_addr) + 1'b1)); // R4

    AST_ROW_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && col_tc) |=> (wr_addr == $past(wr_addr) + AW'(3))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !start) |=> $stable(wr_addr)); // R6

    AST_INTERIOR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) >= LO_A && int'(wr_addr) <= HI_A
                   && (int'(wr_addr) % IMG_DIM) != 0
                   && (int'(wr_addr) % IMG_DIM) != IMG_DIM - 1)); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(wr_addr))); // R8

    AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!wr_en && $past(wr_en) && $past(int'(wr_addr)) == HI_A)); // R8

endmodule

bind interior_addr_gen interior_addr_gen_chk #(
    .IMG_DIM (IMG_DIM),
    .AW      ($clog2(IMG_DIM * IMG_DIM))
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .en      (en),
    .wr_addr (wr_addr),
    .wr_en   (wr_en),
    .done    (done),
    .col_tc  (col_tc)
);

// File: tb/interior_addr_gen_tb_top.sv
// Bench: a behavioural reference, the list of interior addresses plus a
// cursor into it, is compared with the outputs on every clock.
module interior_addr_gen_tb_top;

    localparam int N  = 16;
    localparam int AW = $clog2(N * N);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          en;
    logic [AW-1:0] wr_addr;
    logic          wr_en;
    logic          done;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  ref_q[$];
    int  m_idx   = 0;
    bit  m_run   = 0;
    bit  m_done  = 0;
    int  m_hold  = 0;

    always #5 clk = ~clk;

    interior_addr_gen #(.IMG_DIM(N)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .en      (en),
        .wr_addr (wr_addr),
        .wr_en   (wr_en),
        .done    (done)
    );

    // Compare one value, count it, report a mismatch.
    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, check the strobe, then the state after the edge.
    task automatic cyc(input bit s, input bit e);
        bit exp_we;
        @(negedge clk);
        start = s;
        en    = e;
        #1;
        exp_we = e && m_run && !s;
        chk(exp_we ? "R3" : "R9", int'(wr_en), int'(exp_we));
        if (exp_we) chk("R7", int'(wr_addr), ref_q[m_idx]);
        @(posedge clk);
        if (s) begin
            m_run = 1; m_done = 0; m_idx = 0;
        end else if (exp_we) begin
            m_idx++;
            if (m_idx == ref_q.size()) begin
                m_run = 0; m_done = 1;
            end
        end
        #1;
        chk("R8", int'(done), int'(m_done));
        if (s) begin
            chk("R2", int'(wr_addr), N + 1);
        end else if (m_run) begin
            if (!exp_we)                    chk("R6", int'(wr_addr), ref_q[m_idx]);
            else if (m_idx % (N - 2) == 0)  chk("R5", int'(wr_addr), ref_q[m_idx]);
            else                            chk("R4", int'(wr_addr), ref_q[m_idx]);
        end else if (m_done) begin
            if (exp_we) m_hold = int'(wr_addr);
            else        chk("R9", int'(wr_addr), m_hold);
        end else begin
            chk("R9", int'(wr_addr), 0);
        end
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(2_000_000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int r = 1; r <= N - 2; r++)
            for (int c = 1; c <= N - 2; c++)
                ref_q.push_back(r * N + c);

        rst_n = 1'b0; start = 1'b0; en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", int'(wr_en), 0);
        chk("R1", int'(done), 0);
        chk("R1", int'(wr_addr), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Enables before any start are ignored (R9).
        for (int i = 0; i < 5; i++) cyc(0, 1);

        // Full frame, enable every cycle (R4, R5, R7, R8).
        cyc(1, 0);
        while (m_run) cyc(0, 1);
        // Enables after completion are ignored (R9).
        for (int i = 0; i < 6; i++) cyc(0, 1);

        // Full frame with a gapped enable pattern (R6).
        cyc(1, 0);
        for (int i = 0; m_run; i++) cyc(0, (i % 3) != 1);
        cyc(0, 0);

        // Restart mid-frame, with start and en together (R2).
        cyc(1, 1);
        for (int i = 0; i < 40; i++) cyc(0, (i % 2) == 0);
        cyc(1, 1);
        while (m_run) cyc(0, 1);
        for (int i = 0; i < 3; i++) cyc(0, 1);

        // Reset in the middle of a frame (R1).
        cyc(1, 0);
        for (int i = 0; i < 10; i++) cyc(0, 1);
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", int'(wr_addr), 0);
        chk("R1", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        m_run = 0; m_done = 0; m_idx = 0;
        for (int i = 0; i < 3; i++) cyc(0, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule